// File: doc/BRIEF.md
# Phase-Angle Triac Firing Timer

This block converts a qualified mains zero-crossing event and a 4-bit firing level into a triac gate drive signal. Each half-period of the line is divided into `LEVELS` equal steps. An accepted crossing starts a delay of `level * (HALF_TICKS / LEVELS)` ticks. When the delay ends, the block drives a gate pulse whose width is set in ticks. A tick is a clock-rate enable that comes from outside the block. With the 60 Hz defaults, a 45 degree delay is about 2.08 ms, and the load then sees roughly 114 V RMS of a 120 V RMS supply.

The block has four modes:
- **Half-cycle mode:** every crossing re-arms the timer.
- **Full-cycle mode:** only crossings marked as the reference polarity re-arm it. The block then fires a second pulse exactly one half-period (`HALF_TICKS` ticks) after the first, so both half-cycles conduct at the same angle.
- **Steady mode:** the gate is held on for as long as the mode is selected. With the carrier select set, the gate instead carries a square-wave carrier timed in clock cycles, for pulse-transformer drive. The carrier can be set in the 10 to 15 kHz range through `CARRIER_HALF`.
- **Off mode:** the gate is held inactive.

Top module: `triac_phase_fire`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the gate output is low and no firing is pending.
- R2: In half-cycle mode (mode = 0), any crossing accepted at a clock edge, of either polarity, starts a firing. With a tick on every cycle, the gate goes high `level*STEP` cycles after the accepting edge (STEP = HALF_TICKS/LEVELS, which is 10 by default) and the block fires only once.
- R3: The gate pulse lasts `pulse_ticks` ticks, captured when the crossing is accepted. A value of 0 gives 1 tick. Values of `HALF_TICKS` or more are limited to `HALF_TICKS-1`.
- R4: In full-cycle mode (mode = 1), the block accepts a crossing only when `zc_pol` = 1. It then fires a second pulse of the same width that starts exactly `HALF_TICKS` ticks after the start of the first pulse.
- R5: In full-cycle mode, a crossing with `zc_pol` = 0 is ignored. It neither starts a firing nor disturbs one that is pending.
- R6: A crossing accepted while a firing sequence is in progress cancels that sequence, including a pulse in progress. The delay then restarts from the new crossing with the new level.
- R7: The delay, pulse and half-period counters advance only on cycles where `tick` = 1. Crossings are accepted whether or not a tick is present.
- R8: In steady mode (mode = 2) with `carrier_sel` = 0, the gate is high from the first edge at which the mode and enable are seen, and it stays high while they are held. Crossings have no effect in this mode.
- R9: In steady mode with `carrier_sel` = 1, the gate is a square wave that starts high: `CARRIER_HALF` cycles high, then `CARRIER_HALF` cycles low, repeating (4 and 4 by default).
- R10: While `enable` is low, the gate is low from the next edge onwards and any pending firing is cancelled. Re-enabling the block does not fire it unless a new crossing arrives.
- R11: In off mode (mode = 3), the gate is low from the next edge and crossings are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable for the firing counters |
| zc_event | input | 1 | Single-cycle pulse marking a qualified zero crossing |
| zc_pol | input | 1 | Crossing polarity; 1 marks the full-cycle reference crossing |
| level | input | $clog2(LEVELS) | Firing level that selects the delay |
| pulse_ticks | input | PW_W | Gate pulse width in ticks |
| mode | input | 2 | 0 half-cycle, 1 full-cycle, 2 steady, 3 off |
| enable | input | 1 | Block enable; low forces the gate inactive |
| carrier_sel | input | 1 | In steady mode, output the carrier instead of a constant level |
| gate | output | 1 | Triac gate drive, active high |

## Verification
Every result here appears a known number of edges after the edge that accepts a crossing or sees a mode change. A delayed pulse rises `level*STEP` cycles later. A full-cycle second pulse rises `HALF_TICKS` cycles after the first. The carrier and the steady level appear one edge after steady mode is selected, and the disable and off modes clear the gate at the next edge. The bench drives inputs on falling edges and labels each falling-edge sample with the number of rising edges since the accepting edge, so every expected index maps directly to the cycle counts in R2 to R11. When the tick is stalled, or a crossing is injected during a sequence, the bench resets that index at the point where the counter value is known.

// File: rtl/triac_fire_pkg.sv
package triac_fire_pkg;

    typedef enum logic [1:0] {
        MODE_HALF   = 2'd0,
        MODE_FULL   = 2'd1,
        MODE_STEADY = 2'd2,
        MODE_OFF    = 2'd3
    } fire_mode_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_DELAY,
        SEQ_PULSE,
        SEQ_GAP,
        SEQ_PULSE2
    } seq_state_e;

    typedef struct packed {
        logic accept;
        logic twice;
    } zc_qual_t;

    function automatic int unsigned delay_for_level(input int unsigned lvl,
                                                    input int unsigned step);
        return lvl * step;
    endfunction

    function automatic int unsigned clamp_width(input int unsigned req,
                                                input int unsigned half);
        if (req == 0)
            return 1;
        else if (req >= half)
            return half - 1;
        else
            return req;
    endfunction

endpackage

// File: rtl/tfire_zc_qualify.sv
module tfire_zc_qualify
    import triac_fire_pkg::*;
(
    input  logic       enable,
    input  logic [1:0] mode,
    input  logic       zc_event,
    input  logic       zc_pol,
    output logic       run_ok,
    output zc_qual_t   qual
);
    fire_mode_e mode_e;

    always_comb begin
        mode_e      = fire_mode_e'(mode);
        run_ok      = enable && (mode_e == MODE_HALF || mode_e == MODE_FULL);
        qual.twice  = (mode_e == MODE_FULL);
        qual.accept = run_ok && zc_event && ((mode_e == MODE_HALF) || zc_pol);
    end
endmodule

// File: rtl/tfire_sequencer.sv
module tfire_sequencer
    import triac_fire_pkg::*;
#(
    parameter int HALF_TICKS = 160,
    parameter int LEVELS     = 16,
    parameter int PW_W       = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      run_ok,
    input  zc_qual_t                  qual,
    input  logic [$clog2(LEVELS)-1:0] level,
    input  logic [PW_W-1:0]           pulse_ticks,
    output logic                      seq_gate
);
    localparam int STEP  = HALF_TICKS / LEVELS;
    localparam int CNT_W = $clog2(HALF_TICKS + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] width_q;
    logic             twice_q;

    int unsigned      dly_new;
    int unsigned      wid_new;
    logic             cnt_last;

    always_comb begin
        dly_new  = delay_for_level(int'(level), STEP);
        wid_new  = clamp_width(int'(pulse_ticks), HALF_TICKS);
        cnt_last = (cnt_q == CNT_W'(1));
        seq_gate = (state_q == SEQ_PULSE) || (state_q == SEQ_PULSE2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            width_q <= CNT_W'(1);
            twice_q <= 1'b0;
        end else if (!run_ok) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (qual.accept) begin
            width_q <= CNT_W'(wid_new);
            twice_q <= qual.twice;
            if (dly_new == 0) begin
                state_q <= SEQ_PULSE;
                cnt_q   <= CNT_W'(wid_new);
            end else begin
                state_q <= SEQ_DELAY;
                cnt_q   <= CNT_W'(dly_new);
            end
        end else if (tick) begin
            unique case (state_q)
                SEQ_DELAY: begin
                    if (cnt_last) begin
                        state_q <= SEQ_PULSE;
                        cnt_q   <= width_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                SEQ_PULSE: begin
                    if (cnt_last) begin
                        if (twice_q) begin
                            state_q <= SEQ_GAP;
                            cnt_q   <= CNT_W'(HALF_TICKS) - width_q;
                        end else begin
                            state_q <= SEQ_IDLE;
                            cnt_q   <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                SEQ_GAP: begin
                    if (cnt_last) begin
                        state_q <= SEQ_PULSE2;
                        cnt_q   <= width_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                SEQ_PULSE2: begin
                    if (cnt_last) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tfire_steady_drive.sv
module tfire_steady_drive
    import triac_fire_pkg::*;
#(
    parameter int CARRIER_HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [1:0] mode,
    input  logic       carrier_sel,
    output logic       steady_gate
);
    localparam int CW = (CARRIER_HALF > 1) ? $clog2(CARRIER_HALF) : 1;

    logic          steady_q;
    logic          phase_q;
    logic [CW-1:0] ccnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            steady_q <= 1'b0;
            phase_q  <= 1'b1;
            ccnt_q   <= '0;
        end else begin
            steady_q <= enable && (fire_mode_e'(mode) == MODE_STEADY);
            if (!steady_q) begin
                phase_q <= 1'b1;
                ccnt_q  <= '0;
            end else if (ccnt_q == CW'(CARRIER_HALF - 1)) begin
                phase_q <= ~phase_q;
                ccnt_q  <= '0;
            end else begin
                ccnt_q <= ccnt_q + CW'(1);
            end
        end
    end

    assign steady_gate = steady_q && (carrier_sel ? phase_q : 1'b1);
endmodule

// File: rtl/triac_phase_fire.sv
module triac_phase_fire
    import triac_fire_pkg::*;
#(
    parameter int HALF_TICKS   = 160,
    parameter int LEVELS       = 16,
    parameter int PW_W         = 8,
    parameter int CARRIER_HALF = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      zc_event,
    input  logic                      zc_pol,
    input  logic [$clog2(LEVELS)-1:0] level,
    input  logic [PW_W-1:0]           pulse_ticks,
    input  logic [1:0]                mode,
    input  logic                      enable,
    input  logic                      carrier_sel,
    output logic                      gate
);
    logic     run_ok;
    zc_qual_t qual;
    logic     seq_gate;
    logic     steady_gate;

    tfire_zc_qualify u_qual (
        .enable   (enable),
        .mode     (mode),
        .zc_event (zc_event),
        .zc_pol   (zc_pol),
        .run_ok   (run_ok),
        .qual     (qual)
    );

    tfire_sequencer #(
        .HALF_TICKS (HALF_TICKS),
        .LEVELS     (LEVELS),
        .PW_W       (PW_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .run_ok      (run_ok),
        .qual        (qual),
        .level       (level),
        .pulse_ticks (pulse_ticks),
        .seq_gate    (seq_gate)
    );

    tfire_steady_drive #(
        .CARRIER_HALF (CARRIER_HALF)
    ) u_steady (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .mode        (mode),
        .carrier_sel (carrier_sel),
        .steady_gate (steady_gate)
    );

    assign gate = seq_gate | steady_gate;
endmodule

// File: rtl/tfire_checker.sv
module tfire_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [1:0] mode,
    input logic       carrier_sel,
    input logic       gate
);
    // R1: the edge that samples reset leaves the gate low
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !gate)
        else $error("p_reset_idle_r1");

    // R10: disabling clears the gate at the next edge
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !gate)
        else $error("p_disable_idle_r10");

    // R11: off mode clears the gate at the next edge
    p_off_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> !gate)
        else $error("p_off_idle_r11");

    // R8: steady mode without carrier holds the gate high
    p_steady_on_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && mode == 2'd2 && !carrier_sel) |=> (gate || carrier_sel))
        else $error("p_steady_on_r8");
endmodule

bind triac_phase_fire tfire_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .mode        (mode),
    .carrier_sel (carrier_sel),
    .gate        (gate)
);

// File: tb/triac_phase_fire_tb_top.sv
module triac_phase_fire_tb_top;
    localparam int HALF = 160;
    localparam int STEP = 10;
    localparam int CH   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       zc_event = 1'b0;
    logic       zc_pol = 1'b0;
    logic [3:0] level = '0;
    logic [7:0] pulse_ticks = 8'd1;
    logic [1:0] mode = 2'd0;
    logic       enable = 1'b1;
    logic       carrier_sel = 1'b0;
    logic       gate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    triac_phase_fire dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .zc_event    (zc_event),
        .zc_pol      (zc_pol),
        .level       (level),
        .pulse_ticks (pulse_ticks),
        .mode        (mode),
        .enable      (enable),
        .carrier_sel (carrier_sel),
        .gate        (gate)
    );

    typedef struct packed {
        logic [3:0] lvl;
        logic [1:0] md;
        logic       pol;
        logic [7:0] w;
        logic [9:0] rise;
        logic [7:0] wexp;
        logic [9:0] rise2;
        logic       has2;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{lvl: 4'd3,  md: 2'd0, pol: 1'b1, w: 8'd5,   rise: 10'd30,  wexp: 8'd5,   rise2: 10'd0,   has2: 1'b0},
        '{lvl: 4'd0,  md: 2'd0, pol: 1'b0, w: 8'd4,   rise: 10'd0,   wexp: 8'd4,   rise2: 10'd0,   has2: 1'b0},
        '{lvl: 4'd15, md: 2'd0, pol: 1'b0, w: 8'd1,   rise: 10'd150, wexp: 8'd1,   rise2: 10'd0,   has2: 1'b0},
        '{lvl: 4'd2,  md: 2'd1, pol: 1'b1, w: 8'd6,   rise: 10'd20,  wexp: 8'd6,   rise2: 10'd180, has2: 1'b1},
        '{lvl: 4'd0,  md: 2'd1, pol: 1'b1, w: 8'd0,   rise: 10'd0,   wexp: 8'd1,   rise2: 10'd160, has2: 1'b1},
        '{lvl: 4'd1,  md: 2'd1, pol: 1'b1, w: 8'd200, rise: 10'd10,  wexp: 8'd159, rise2: 10'd170, has2: 1'b1},
        '{lvl: 4'd4,  md: 2'd0, pol: 1'b0, w: 8'd255, rise: 10'd40,  wexp: 8'd159, rise2: 10'd0,   has2: 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pulse a crossing; returns at the falling edge after the accepting edge.
    task automatic pulse_zc(input logic [3:0] lvl, input logic pol);
        @(negedge clk);
        level    = lvl;
        zc_pol   = pol;
        zc_event = 1'b1;
        @(negedge clk);
        zc_event = 1'b0;
    endtask

    // Count highs over n samples, starting with the current one.
    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (gate) highs++;
        end
    endtask

    task automatic measure(input int exp_rise, input int exp_w,
                           input int exp_rise2, input string req);
        int   r1 = -1, w1 = 0, r2 = -1, w2 = 0, edges = 0;
        logic prev = 1'b0;
        for (int k = 0; k < 2 * HALF + 200; k++) begin
            if (k > 0) @(negedge clk);
            if (gate && !prev) begin
                edges++;
                if (edges == 1) r1 = k;
                else if (edges == 2) r2 = k;
            end
            if (gate && edges == 1) w1++;
            if (gate && edges == 2) w2++;
            prev = gate;
        end
        check(r1 == exp_rise, req, "first rise index", r1, exp_rise);
        check(w1 == exp_w, "R3", "first pulse width", w1, exp_w);
        check(r2 == exp_rise2, req, "second rise index", r2, exp_rise2);
        if (exp_rise2 >= 0)
            check(w2 == exp_w, "R3", "second pulse width", w2, exp_w);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int h;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(gate == 1'b0, "R1", "gate in reset", int'(gate), 0);
        rst = 1'b0;
        @(negedge clk);
        check(gate == 1'b0, "R1", "gate after reset", int'(gate), 0);

        // Vector table: R2 / R3 / R4
        foreach (VECS[i]) begin
            @(negedge clk);
            mode        = VECS[i].md;
            pulse_ticks = VECS[i].w;
            pulse_zc(VECS[i].lvl, VECS[i].pol);
            measure(int'(VECS[i].rise), int'(VECS[i].wexp),
                    VECS[i].has2 ? int'(VECS[i].rise2) : -1,
                    VECS[i].has2 ? "R4" : "R2");
        end

        // R5: opposite-polarity crossing ignored in full-cycle mode
        mode = 2'd1; pulse_ticks = 8'd3;
        pulse_zc(4'd5, 1'b0);
        count_high(300, h);
        check(h == 0, "R5", "highs after ignored crossing", h, 0);
        pulse_zc(4'd5, 1'b1);
        repeat (10) @(negedge clk);
        pulse_zc(4'd2, 1'b0);
        measure(38, 3, 38 + HALF, "R5");

        // R6: retrigger cancels pending firing and restarts delay
        mode = 2'd0; pulse_ticks = 8'd3;
        pulse_zc(4'd5, 1'b1);
        count_high(21, h);
        pulse_zc(4'd2, 1'b0);
        check(h == 0, "R6", "highs before retrigger", h, 0);
        measure(20, 3, -1, "R6");
        // R6: retrigger during a pulse drops the gate
        pulse_ticks = 8'd40;
        pulse_zc(4'd0, 1'b1);
        repeat (5) @(negedge clk);
        pulse_zc(4'd3, 1'b1);
        check(gate == 1'b0, "R6", "gate after retrigger mid-pulse", int'(gate), 0);
        measure(30, 40, -1, "R6");

        // R7: counters stall without tick
        pulse_ticks = 8'd4;
        tick = 1'b0;
        pulse_zc(4'd2, 1'b1);
        count_high(31, h);
        check(h == 0, "R7", "highs while tick stalled", h, 0);
        tick = 1'b1;
        measure(20, 4, -1, "R7");

        // R10: disable cancels pending and active firings
        pulse_zc(4'd3, 1'b1);
        repeat (10) @(negedge clk);
        enable = 1'b0;
        repeat (5) @(negedge clk);
        enable = 1'b1;
        count_high(200, h);
        check(h == 0, "R10", "highs after disable of pending firing", h, 0);
        pulse_ticks = 8'd40;
        pulse_zc(4'd0, 1'b1);
        repeat (5) @(negedge clk);
        check(gate == 1'b1, "R10", "gate mid-pulse before disable", int'(gate), 1);
        enable = 1'b0;
        @(negedge clk);
        check(gate == 1'b0, "R10", "gate after disable", int'(gate), 0);
        enable = 1'b1;
        count_high(100, h);
        check(h == 0, "R10", "highs after re-enable", h, 0);

        // R8: steady on, crossings have no effect
        mode = 2'd2; carrier_sel = 1'b0;
        @(negedge clk);
        h = 0;
        for (int k = 0; k < 40; k++) begin
            if (k > 0) @(negedge clk);
            if (gate) h++;
            zc_event = (k == 10);
        end
        zc_event = 1'b0;
        check(h == 40, "R8", "steady high samples", h, 40);

        // R11: off mode
        mode = 2'd3;
        @(negedge clk);
        check(gate == 1'b0, "R11", "gate after off", int'(gate), 0);
        pulse_zc(4'd0, 1'b1);
        count_high(200, h);
        check(h == 0, "R11", "highs in off mode", h, 0);

        // R9: carrier pattern in steady mode
        mode = 2'd2; carrier_sel = 1'b1;
        @(negedge clk);
        h = 0;
        for (int k = 0; k < 8 * CH; k++) begin
            if (k > 0) @(negedge clk);
            if (gate != (((k / CH) % 2) == 0)) h++;
        end
        check(h == 0, "R9", "carrier mismatches", h, 0);
        enable = 1'b0;
        @(negedge clk);
        check(gate == 1'b0, "R10", "steady gate after disable", int'(gate), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule